// File: doc/BRIEF.md
# Frame-Timed Register Write Sequencer

This block is a tiny timing processor for a radio front end. A host loads a short program of 16-bit words into a local instruction memory, then raises a run bit. The sequencer starts at word zero and steps through the program. Some instructions stall until a free-running frame-time counter reaches a given value. Some stall for a fixed number of clock cycles. Others write an 8-bit value to a peripheral register over a narrow write bus, or retime the counter. An all-zero word puts the sequencer back to idle.

The frame-time counter runs continuously while the clock-enable bit is set. It wraps at a programmable limit. A frame boundary is the cycle in which the counter reaches the current offset value. At each boundary the block can raise a frame interrupt, and it can raise a single armed DSP interrupt. A mask register gates both interrupts. A control register holds the reset, enable and arm bits, and it reports a busy flag.

Top module: `frame_seq`

## Requirements
- R1: Each instruction word holds an opcode in bits [15:13] and an operand in bits [12:0]. The opcodes are 0 sleep, 1 at, 2 wait, 3 move, 4 offset and 5 synchro; codes 6 and 7 are no-ops. A sleep word returns the sequencer to idle, and `ctl_rdata[6]` (busy) reads 0 in the cycle after it executes.
- R2: A rise of the run bit (`ctl_wdata[4]`) starts execution at address 0 no later than 24 cycles after the write. `ctl_rdata[4]` shows the run bit only once the sequencer has taken it up, which is EN_DELAY cycles after the write.
- R3: An at instruction holds execution, with busy at 1, until `frame_time` equals its operand. An instruction right after it that executes on the following cycle therefore sees `frame_time` equal to the operand plus 2 when its effect reaches the ports.
- R4: A wait N instruction (N > 0) puts N stall cycles between itself and the next instruction, so two moves placed around it strobe N+2 cycles apart. Wait 0 adds no stall, so the gap is 2 cycles.
- R5: A move instruction gives one `rw_stb` pulse with `rw_addr` = bits [12:8] and `rw_data` = bits [7:0]. It strobes only while the sequencer is busy.
- R6: `frame_time` counts from 0 up to FRAME_LIMIT and then wraps to 0. `frame_irq` is a single-cycle pulse in the cycle in which `frame_time` arrives at the offset, which is 0 after reset. Mask bit 0 (`msk_rdata[0]`) suppresses the pulse. Unmasked pulses come FRAME_LIMIT+1 cycles apart.
- R7: An offset instruction loads its operand as the new frame-boundary position.
- R8: A synchro instruction loads its operand into the frame-time counter, and counting continues from there. An operand above FRAME_LIMIT loads 0.
- R9: Writing 1 to `ctl_wdata[5]` arms the DSP interrupt. At the next frame boundary `dsp_irq` pulses once, unless mask bit 2 is set, and the hardware clears the arm bit whether or not the pulse was masked.
- R10: Control bits 0 to 3 and 5, and the three mask bits, read back as they were written. Control resets to all zeros and the mask resets to 3'b111. Control bits 1 and 2 drive `periph_rst[0]` and `periph_rst[1]`.
- R11: With clock enable (`ctl_wdata[3]`) at 0, the counter and the sequencer hold their state.
- R12: While the sequencer-reset bit (`ctl_wdata[0]`) is set, the sequencer goes idle and the counter and the offset are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Instruction memory write strobe |
| prog_addr | input | log2(IMEM_DEPTH) | Instruction memory word address |
| prog_data | input | 16 | Instruction word to store |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control value: 0 seq reset, 1 serial reset, 2 SPI reset, 3 clock enable, 4 run, 5 DSP arm |
| ctl_rdata | output | 7 | Control readback, bit 6 busy |
| msk_we | input | 1 | Interrupt mask write strobe |
| msk_wdata | input | 3 | Mask value: 0 frame, 1 page, 2 DSP |
| msk_rdata | output | 3 | Mask readback |
| periph_rst | output | 2 | Serial-port and SPI reset levels |
| rw_addr | output | 5 | Peripheral register address |
| rw_data | output | 8 | Peripheral register data |
| rw_stb | output | 1 | Peripheral write strobe |
| frame_time | output | 13 | Frame-time counter value |
| frame_irq | output | 1 | Frame interrupt pulse |
| dsp_irq | output | 1 | DSP interrupt pulse |

## Verification
A table of at-then-move programs spreads the at targets across the frame and pairs them with register addresses from 0 to 31 and data from 0x00 to 0xFF. These runs show that the at stall releases on the exact count and that the address and data fields are not swapped or shifted. Mixed move and wait programs, with wait 5 and wait 0, separate an off-by-one in the stall counter from a missing stall. Synchro runs with an in-range and an out-of-range operand separate the counter reload from the clamp. Offset, masking and arming sequences show where the frame boundary lies and that the DSP interrupt fires only once.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

  localparam int TIME_W = 13;
  localparam int WORD_W = 16;
  localparam int RADDR_W = 5;
  localparam int RDATA_W = 8;

  // control bit positions
  localparam int CB_SRST = 0;
  localparam int CB_SERR = 1;
  localparam int CB_SPIR = 2;
  localparam int CB_CKEN = 3;
  localparam int CB_RUN  = 4;
  localparam int CB_DSP  = 5;
  localparam int CB_BUSY = 6;

  // mask bit positions
  localparam int MB_FRAME = 0;
  localparam int MB_PAGE  = 1;
  localparam int MB_DSP   = 2;

  typedef enum logic [2:0] {
    OP_SLEEP  = 3'd0,
    OP_AT     = 3'd1,
    OP_WAIT   = 3'd2,
    OP_MOVE   = 3'd3,
    OP_OFFSET = 3'd4,
    OP_SYNC   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_STALL = 2'd2
  } seq_st_e;

  function automatic logic [2:0] op_field(input logic [WORD_W-1:0] w);
    return w[15:13];
  endfunction

  function automatic logic [TIME_W-1:0] opnd_field(input logic [WORD_W-1:0] w);
    return w[12:0];
  endfunction

  function automatic logic [RADDR_W-1:0] mv_addr(input logic [WORD_W-1:0] w);
    return w[12:8];
  endfunction

  function automatic logic [RDATA_W-1:0] mv_data(input logic [WORD_W-1:0] w);
    return w[7:0];
  endfunction

  // next counter value: wrap after the limit
  function automatic logic [TIME_W-1:0] time_step(input logic [TIME_W-1:0] t,
                                                  input logic [TIME_W-1:0] lim);
    return (t >= lim) ? '0 : t + 1'b1;
  endfunction

  // out-of-range time operands fold to zero
  function automatic logic [TIME_W-1:0] clamp_time(input logic [TIME_W-1:0] v,
                                                   input logic [TIME_W-1:0] lim);
    return (v > lim) ? '0 : v;
  endfunction

endpackage

// File: rtl/fs_ctrl.sv
module fs_ctrl
  import frame_seq_pkg::*;
#(
  parameter int EN_DELAY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [5:0] ctl_wdata,
  input  logic       msk_we,
  input  logic [2:0] msk_wdata,
  input  logic       busy,
  input  logic       frame_tick,
  output logic       seq_rst,
  output logic       clk_en,
  output logic       start,
  output logic [1:0] periph_rst,
  output logic [6:0] ctl_rdata,
  output logic [2:0] msk_rdata,
  output logic       frame_irq,
  output logic       dsp_irq
);

  logic [5:0]        ctl_q;
  logic [2:0]        msk_q;
  logic [EN_DELAY:0] en_pipe;
  logic              run_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      msk_q     <= 3'b111;
      en_pipe   <= '0;
      frame_irq <= 1'b0;
      dsp_irq   <= 1'b0;
    end else begin
      en_pipe   <= {en_pipe[EN_DELAY-1:0], ctl_q[CB_RUN]};
      frame_irq <= frame_tick & ~msk_q[MB_FRAME];
      dsp_irq   <= frame_tick & ctl_q[CB_DSP] & ~msk_q[MB_DSP];
      if (msk_we) msk_q <= msk_wdata;
      if (ctl_we) ctl_q <= ctl_wdata;
      else if (frame_tick) ctl_q[CB_DSP] <= 1'b0;
    end
  end

  assign run_eff    = en_pipe[EN_DELAY-1];
  assign start      = run_eff & ~en_pipe[EN_DELAY];
  assign seq_rst    = ctl_q[CB_SRST];
  assign clk_en     = ctl_q[CB_CKEN];
  assign periph_rst = {ctl_q[CB_SPIR], ctl_q[CB_SERR]};
  assign ctl_rdata  = {busy, ctl_q[CB_DSP], run_eff, ctl_q[3:0]};
  assign msk_rdata  = msk_q;

endmodule

// File: rtl/fs_timebase.sv
module fs_timebase
  import frame_seq_pkg::*;
#(
  parameter int LIMIT = 4999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic              clk_en,
  input  logic              sync_ld,
  input  logic              off_ld,
  input  logic [TIME_W-1:0] opnd,
  output logic [TIME_W-1:0] time_q,
  output logic [TIME_W-1:0] off_q,
  output logic              tick
);

  localparam logic [TIME_W-1:0] LIM = TIME_W'(LIMIT);

  logic [TIME_W-1:0] stepped;

  assign stepped = time_step(time_q, LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      off_q  <= '0;
    end else if (seq_rst) begin
      time_q <= '0;
      off_q  <= '0;
    end else if (clk_en) begin
      time_q <= sync_ld ? clamp_time(opnd, LIM) : stepped;
      if (off_ld) off_q <= clamp_time(opnd, LIM);
    end
  end

  // boundary: counter steps (not reloaded) onto the offset
  assign tick = clk_en & ~seq_rst & ~sync_ld & (stepped == off_q);

endmodule

// File: rtl/fs_core.sv
module fs_core
  import frame_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seq_rst,
  input  logic               clk_en,
  input  logic               start,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [WORD_W-1:0]  prog_data,
  input  logic [TIME_W-1:0]  time_q,
  output logic               busy,
  output logic               sync_ld,
  output logic               off_ld,
  output logic [TIME_W-1:0]  opnd,
  output logic [RADDR_W-1:0] rw_addr,
  output logic [RDATA_W-1:0] rw_data,
  output logic               rw_stb
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     pc;
  seq_st_e           state;
  logic [TIME_W-1:0] wcnt;
  logic [WORD_W-1:0] instr;
  logic [2:0]        op;
  logic              exec;
  logic              at_hit;

  always_ff @(posedge clk) begin
    if (prog_we) mem[prog_addr] <= prog_data;
  end

  assign instr  = mem[pc];
  assign op     = op_field(instr);
  assign opnd   = opnd_field(instr);
  assign at_hit = (time_q == opnd);
  assign exec   = clk_en & ~seq_rst & ~start & (state == ST_RUN);
  assign sync_ld = exec & (op == OP_SYNC);
  assign off_ld  = exec & (op == OP_OFFSET);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pc      <= '0;
      wcnt    <= '0;
      rw_stb  <= 1'b0;
      rw_addr <= '0;
      rw_data <= '0;
    end else begin
      rw_stb <= 1'b0;
      if (seq_rst) begin
        state <= ST_IDLE;
        pc    <= '0;
        wcnt  <= '0;
      end else if (clk_en) begin
        if (start) begin
          state <= ST_RUN;
          pc    <= '0;
        end else begin
          case (state)
            ST_RUN: begin
              case (op)
                OP_SLEEP: state <= ST_IDLE;
                OP_AT: if (at_hit) pc <= pc + 1'b1;
                OP_WAIT: begin
                  pc <= pc + 1'b1;
                  if (opnd != '0) begin
                    wcnt  <= opnd;
                    state <= ST_STALL;
                  end
                end
                OP_MOVE: begin
                  pc      <= pc + 1'b1;
                  rw_stb  <= 1'b1;
                  rw_addr <= mv_addr(instr);
                  rw_data <= mv_data(instr);
                end
                default: pc <= pc + 1'b1;
              endcase
            end
            ST_STALL: begin
              wcnt <= wcnt - 1'b1;
              if (wcnt == TIME_W'(1)) state <= ST_RUN;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int FRAME_LIMIT = 4999,
  parameter int IMEM_DEPTH  = 64,
  parameter int EN_DELAY    = 3,
  parameter int PA_W        = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [PA_W-1:0] prog_addr,
  input  logic [15:0]     prog_data,
  input  logic            ctl_we,
  input  logic [5:0]      ctl_wdata,
  output logic [6:0]      ctl_rdata,
  input  logic            msk_we,
  input  logic [2:0]      msk_wdata,
  output logic [2:0]      msk_rdata,
  output logic [1:0]      periph_rst,
  output logic [4:0]      rw_addr,
  output logic [7:0]      rw_data,
  output logic            rw_stb,
  output logic [12:0]     frame_time,
  output logic            frame_irq,
  output logic            dsp_irq
);

  logic              seq_rst;
  logic              clk_en;
  logic              start;
  logic              busy;
  logic              frame_tick;
  logic              sync_ld;
  logic              off_ld;
  logic [TIME_W-1:0] opnd;
  logic [TIME_W-1:0] offset_val;

  fs_ctrl #(.EN_DELAY(EN_DELAY)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .msk_we     (msk_we),
    .msk_wdata  (msk_wdata),
    .busy       (busy),
    .frame_tick (frame_tick),
    .seq_rst    (seq_rst),
    .clk_en     (clk_en),
    .start      (start),
    .periph_rst (periph_rst),
    .ctl_rdata  (ctl_rdata),
    .msk_rdata  (msk_rdata),
    .frame_irq  (frame_irq),
    .dsp_irq    (dsp_irq)
  );

  fs_timebase #(.LIMIT(FRAME_LIMIT)) u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .seq_rst (seq_rst),
    .clk_en  (clk_en),
    .sync_ld (sync_ld),
    .off_ld  (off_ld),
    .opnd    (opnd),
    .time_q  (frame_time),
    .off_q   (offset_val),
    .tick    (frame_tick)
  );

  fs_core #(.DEPTH(IMEM_DEPTH), .AW(PA_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .seq_rst   (seq_rst),
    .clk_en    (clk_en),
    .start     (start),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .time_q    (frame_time),
    .busy      (busy),
    .sync_ld   (sync_ld),
    .off_ld    (off_ld),
    .opnd      (opnd),
    .rw_addr   (rw_addr),
    .rw_data   (rw_data),
    .rw_stb    (rw_stb)
  );

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
  parameter int LIMIT = 4999
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rw_stb,
  input logic        busy,
  input logic        dsp_arm,
  input logic        seq_rst,
  input logic        clk_en,
  input logic        frame_irq,
  input logic        dsp_irq,
  input logic [12:0] frame_time,
  input logic [12:0] offset_val
);

  p_stb_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rw_stb |-> busy);

  p_time_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_time <= 13'(LIMIT));

  p_frame_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |=> !frame_irq);

  p_frame_irq_at_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> frame_time == $past(offset_val));

  p_dsp_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_irq |-> $past(dsp_arm));

  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !seq_rst) |=> $stable(frame_time));

  p_reset_idles_r12: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst |=> (!busy && frame_time == 13'd0));

endmodule

bind frame_seq fs_checker #(.LIMIT(FRAME_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rw_stb     (rw_stb),
  .busy       (ctl_rdata[6]),
  .dsp_arm    (ctl_rdata[5]),
  .seq_rst    (ctl_rdata[0]),
  .clk_en     (ctl_rdata[3]),
  .frame_irq  (frame_irq),
  .dsp_irq    (dsp_irq),
  .frame_time (frame_time),
  .offset_val (offset_val)
);

// File: tb/sim_frame_seq.sv
`timescale 1ns/1ps
module sim_frame_seq;
  localparam int LIM   = 499;
  localparam int DEPTH = 32;
  localparam int EDLY  = 3;
  localparam int AW    = $clog2(DEPTH);

  // {at target[12:0], reg addr[4:0], data[7:0]}
  localparam logic [25:0] VECS [8] = '{
    {13'd5,   5'd0,  8'hA5},
    {13'd37,  5'd31, 8'h00},
    {13'd120, 5'd17, 8'hFF},
    {13'd250, 5'd8,  8'h3C},
    {13'd333, 5'd1,  8'h80},
    {13'd401, 5'd30, 8'h01},
    {13'd480, 5'd16, 8'h7E},
    {13'd490, 5'd5,  8'hC3}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          prog_we;
  logic [AW-1:0] prog_addr;
  logic [15:0]   prog_data;
  logic          ctl_we;
  logic [5:0]    ctl_wdata;
  logic [6:0]    ctl_rdata;
  logic          msk_we;
  logic [2:0]    msk_wdata;
  logic [2:0]    msk_rdata;
  logic [1:0]    periph_rst;
  logic [4:0]    rw_addr;
  logic [7:0]    rw_data;
  logic          rw_stb;
  logic [12:0]   frame_time;
  logic          frame_irq;
  logic          dsp_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  frame_seq #(.FRAME_LIMIT(LIM), .IMEM_DEPTH(DEPTH), .EN_DELAY(EDLY)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .msk_we(msk_we), .msk_wdata(msk_wdata),
    .msk_rdata(msk_rdata), .periph_rst(periph_rst), .rw_addr(rw_addr),
    .rw_data(rw_data), .rw_stb(rw_stb), .frame_time(frame_time),
    .frame_irq(frame_irq), .dsp_irq(dsp_irq)
  );

  function automatic logic [15:0] ins(input int op, input int arg);
    return {3'(op), 13'(arg)};
  endfunction

  function automatic logic [15:0] mv(input int a, input int d);
    return {3'd3, 5'(a), 8'(d)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_msk(input logic [2:0] v);
    msk_we = 1'b1; msk_wdata = v;
    @(negedge clk);
    msk_we = 1'b0;
  endtask

  task automatic put(input int a, input logic [15:0] w);
    prog_we = 1'b1; prog_addr = AW'(a); prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic halt();
    wr_ctl(6'h08);
    cyc(6);
  endtask

  task automatic wait_stb(input int lim, output int n);
    n = 0;
    while (!rw_stb && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wait_frame_irq(input int lim, output int n);
    n = 0;
    while (!frame_irq && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired (R1 run did not finish) actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int tg;
    int v;
    int hits;
    int st [3];
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    ctl_we = 1'b0; ctl_wdata = '0; msk_we = 1'b0; msk_wdata = '0;
    cyc(4);
    rst_n = 1'b1;
    cyc(2);

    // reset state (R10, R6)
    chk(ctl_rdata == 7'd0, "R10 control reset", ctl_rdata, 0);
    chk(msk_rdata == 3'b111, "R10 mask reset", msk_rdata, 7);
    chk(frame_time == 13'd0 && !rw_stb, "R6 reset time", frame_time, 0);
    chk(!frame_irq && !dsp_irq, "R6 reset irqs", frame_irq, 0);

    // table of at/move programs (R3, R5, R1)
    for (int i = 0; i < 8; i++) begin
      halt();
      put(0, ins(1, int'(VECS[i][25:13])));
      put(1, mv(int'(VECS[i][12:8]), int'(VECS[i][7:0])));
      put(2, 16'h0000);
      wr_ctl(6'h18);
      wait_stb(1500, n);
      chk(rw_stb, "R3 strobe after at", rw_stb, 1);
      chk(rw_addr == VECS[i][12:8], "R5 move address", rw_addr, int'(VECS[i][12:8]));
      chk(rw_data == VECS[i][7:0], "R5 move data", rw_data, int'(VECS[i][7:0]));
      chk(frame_time == VECS[i][25:13] + 13'd2, "R3 at release time", frame_time,
          int'(VECS[i][25:13]) + 2);
      cyc(1);
      chk(!ctl_rdata[6] && !rw_stb, "R1 idle after sleep", ctl_rdata[6], 0);
    end

    // enable latency and run readback (R2)
    halt();
    put(0, ins(2, 40));
    put(1, 16'h0000);
    wr_ctl(6'h18);
    chk(!ctl_rdata[4], "R2 run readback before effect", ctl_rdata[4], 0);
    n = 0;
    while (!ctl_rdata[6] && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(ctl_rdata[6] && n <= 24, "R2 start latency", n, 24);
    chk(ctl_rdata[4], "R2 run readback after effect", ctl_rdata[4], 1);

    // wait stalls (R4)
    halt();
    put(0, mv(1, 8'h11));
    put(1, ins(2, 5));
    put(2, mv(2, 8'h22));
    put(3, ins(2, 0));
    put(4, mv(3, 8'h33));
    put(5, 16'h0000);
    wr_ctl(6'h18);
    hits = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (rw_stb && hits < 3) begin
        st[hits] = k;
        hits++;
      end
    end
    chk(hits == 3, "R4 strobe count", hits, 3);
    chk(st[1] - st[0] == 7, "R4 wait 5 gap", st[1] - st[0], 7);
    chk(st[2] - st[1] == 2, "R4 wait 0 gap", st[2] - st[1], 2);

    // frame interrupt and period (R6)
    halt();
    wr_msk(3'b110);
    wait_frame_irq(700, n);
    chk(frame_irq && frame_time == 13'd0, "R6 boundary at offset 0", frame_time, 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_irq && n < 700);
    chk(n == LIM + 1, "R6 frame period", n, LIM + 1);
    wr_msk(3'b111);
    hits = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (frame_irq) hits++;
    end
    chk(hits == 0, "R6 masked frame irq", hits, 0);

    // offset (R7)
    put(0, ins(4, 123));
    put(1, 16'h0000);
    wr_ctl(6'h18);
    cyc(10);
    wr_msk(3'b110);
    wait_frame_irq(700, n);
    chk(frame_irq && frame_time == 13'd123, "R7 boundary at offset", frame_time, 123);
    wr_msk(3'b111);

    // synchro in range and out of range (R8)
    halt();
    put(0, ins(1, 50));
    put(1, ins(5, 400));
    put(2, mv(3, 8'h5A));
    put(3, 16'h0000);
    wr_ctl(6'h18);
    wait_stb(1500, n);
    chk(rw_stb && frame_time == 13'd401, "R8 synchro reload", frame_time, 401);
    halt();
    put(0, ins(5, 7000));
    put(1, mv(4, 8'h66));
    put(2, 16'h0000);
    wr_ctl(6'h18);
    wait_stb(100, n);
    chk(rw_stb && frame_time == 13'd1, "R8 synchro clamp", frame_time, 1);

    // sequencer reset during an at stall (R3, R12)
    halt();
    tg = (int'(frame_time) + 250) % (LIM + 1);
    put(0, ins(1, tg));
    put(1, mv(9, 8'h99));
    put(2, 16'h0000);
    wr_ctl(6'h18);
    cyc(10);
    chk(ctl_rdata[6], "R3 busy while at stalls", ctl_rdata[6], 1);
    wr_ctl(6'h09);
    cyc(1);
    chk(!ctl_rdata[6], "R12 reset idles", ctl_rdata[6], 0);
    chk(frame_time == 13'd0, "R12 reset clears time", frame_time, 0);
    cyc(5);
    chk(frame_time == 13'd0, "R12 time held", frame_time, 0);
    wr_ctl(6'h08);
    wr_msk(3'b110);
    hits = 0;
    v = -1;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (rw_stb) hits++;
      if (frame_irq && v < 0) v = int'(frame_time);
    end
    chk(hits == 0, "R12 aborted program silent", hits, 0);
    chk(v == 0, "R12 offset cleared", v, 0);
    wr_msk(3'b111);

    // DSP interrupt arming (R9)
    wr_msk(3'b011);
    wr_ctl(6'h28);
    chk(ctl_rdata[5], "R9 arm readback", ctl_rdata[5], 1);
    n = 0;
    while (!dsp_irq && n < 700) begin
      @(negedge clk);
      n++;
    end
    chk(dsp_irq && frame_time == 13'd0, "R9 dsp irq at boundary", frame_time, 0);
    cyc(1);
    chk(!ctl_rdata[5], "R9 arm cleared by hardware", ctl_rdata[5], 0);
    hits = 0;
    for (int k = 0; k < 1100; k++) begin
      @(negedge clk);
      if (dsp_irq) hits++;
    end
    chk(hits == 0, "R9 single dsp irq", hits, 0);
    wr_msk(3'b111);
    wr_ctl(6'h28);
    hits = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (dsp_irq) hits++;
    end
    chk(hits == 0, "R9 masked dsp irq", hits, 0);
    chk(!ctl_rdata[5], "R9 masked arm still cleared", ctl_rdata[5], 0);

    // clock enable off freezes (R11)
    wr_ctl(6'h00);
    v = int'(frame_time);
    cyc(20);
    chk(int'(frame_time) == v, "R11 time frozen", frame_time, v);
    wr_ctl(6'h08);
    cyc(3);
    chk(int'(frame_time) != v, "R11 time resumes", frame_time, v + 3);

    // readback of remaining bits (R10)
    wr_msk(3'b101);
    chk(msk_rdata == 3'b101, "R10 mask readback", msk_rdata, 5);
    wr_ctl(6'h0E);
    chk(ctl_rdata == 7'h0E, "R10 control readback", ctl_rdata, 14);
    chk(periph_rst == 2'b11, "R10 peripheral resets", periph_rst, 3);
    wr_ctl(6'h08);
    chk(periph_rst == 2'b00, "R10 peripheral resets clear", periph_rst, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule